// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core whose register set depends on the operating mode. An architectural register number and a 5-bit mode code together pick one physical storage entry. Registers 0–7 and 15 are common to every mode. Each of the five exception modes (fast interrupt, normal interrupt, supervisor, abort, undefined) has its own stack pointer (R13) and link register (R14). The fast-interrupt mode also has its own R8–R12, so its handler can use them without saving anything first. User mode and the privileged system mode use the same, unbanked, set of registers.

The core reads two operands per cycle through combinational read ports. It writes one result per cycle at the clock edge, indexed under the current mode. A separate link port writes the return address into R14 of a chosen target mode when an exception is taken. It can do this in the same cycle as an ordinary write.

Top module: `banked_regfile`

## Requirements
- R1: An active-low reset clears every physical entry to zero. After reset, any register read in any mode returns 0.
- R2: Mode code 10000 (user) and 11111 (system) address the same physical register for every index 0–15.
- R3: A mode code outside the set {10000, 10001, 10010, 10011, 10111, 11011, 11111} behaves exactly as user mode.
- R4: In fast-interrupt mode (10001), registers 8–12 are private. A write to one of them there does not change the user value, and the reverse also holds.
- R5: Each of 10001, 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) has its own R13 and R14. These are separate from every other mode. Registers 0–7 and 15 are shared by all modes.
- R6: A write takes effect at the clock edge. A read in the same cycle returns the old value, and the new value is returned from the next cycle on.
- R7: A link write stores its data into R14 of the bank selected by its own mode input. No other entry changes.
- R8: When a normal write and a link write hit the same physical entry in one cycle, the link data is stored.
- R9: The two read ports are independent. Each returns the entry selected by its own index under the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 5 | Mode code for both reads and the normal write |
| rd_a_idx | input | 4 | Register number, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Register number, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register number |
| wr_data | input | 32 | Normal write data |
| lnk_en | input | 1 | Exception link write enable |
| lnk_mode | input | 5 | Target mode of the link write |
| lnk_data | input | 32 | Return address to store in the target's R14 |

## Verification
A mapping fault shows up at the read ports in the first cycle that reads the affected register. That read returns either a value written under a different mode, or a zero where a written value is expected. The same symptom appears when two banks alias one entry. An aliased entry is also overwritten by a write in another mode, and the corruption stays visible until that register is written again in its own mode. A wrong write priority or timing shows on the cycle right after the write, when the read returns the losing data or the stale value.

// File: rtl/bank_pkg.sv
package bank_pkg;
   localparam int IDX_W      = 4;
   localparam int MODE_W     = 5;
   localparam int ARCH_N     = 1 << IDX_W;
   localparam int FIQ_LO     = 8;
   localparam int FIQ_HI     = 12;
   localparam int FIQ_PRIV_N = FIQ_HI - FIQ_LO + 1;
   localparam int EXC_N      = 5;
   localparam int SP_IDX     = 13;
   localparam int LR_IDX     = 14;
   localparam int PHYS_N     = ARCH_N + FIQ_PRIV_N + 2 * EXC_N;
   localparam int PHYS_W     = $clog2(PHYS_N);
   localparam int EXC_BASE   = ARCH_N + FIQ_PRIV_N;

   typedef enum logic [MODE_W-1:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011,
      M_SYS = 5'b11111
   } mode_e;

   typedef logic [PHYS_W-1:0] phys_t;

   // Exception bank slot for a mode; EXC_N when the mode owns no bank.
   function automatic int bank_slot(logic [MODE_W-1:0] m);
      case (m)
         M_FIQ:   return 0;
         M_IRQ:   return 1;
         M_SVC:   return 2;
         M_ABT:   return 3;
         M_UND:   return 4;
         default: return EXC_N;
      endcase
   endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
   import bank_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic [IDX_W-1:0]  idx,
   output phys_t             phys
);
   int slot;
   int reg_n;

   always_comb begin
      slot  = bank_slot(mode);
      reg_n = int'(idx);
      phys  = phys_t'(reg_n);
      if (slot < EXC_N && (reg_n == SP_IDX || reg_n == LR_IDX))
         phys = phys_t'(EXC_BASE + 2 * slot + (reg_n - SP_IDX));
      else if (slot == 0 && reg_n >= FIQ_LO && reg_n <= FIQ_HI)
         phys = phys_t'(ARCH_N + reg_n - FIQ_LO);
   end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 31,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_n,
   input  logic [AW-1:0]     wa_n,
   input  logic [DATA_W-1:0] wd_n,
   input  logic              we_l,
   input  logic [AW-1:0]     wa_l,
   input  logic [DATA_W-1:0] wd_l,
   input  logic [AW-1:0]     ra0,
   output logic [DATA_W-1:0] rd0,
   input  logic [AW-1:0]     ra1,
   output logic [DATA_W-1:0] rd1
);
   logic [DEPTH-1:0][DATA_W-1:0] ent;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_l && wa_l == AW'(i))
            q <= wd_l;
         else if (we_n && wa_n == AW'(i))
            q <= wd_n;
      end
      assign ent[i] = q;
   end

   assign rd0 = (int'(ra0) < DEPTH) ? ent[ra0] : '0;
   assign rd1 = (int'(ra1) < DEPTH) ? ent[ra1] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cur_mode,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lnk_en,
   input  logic [4:0]        lnk_mode,
   input  logic [DATA_W-1:0] lnk_data
);
   if (DATA_W < 8) begin : g_bad_width
      $error("banked_regfile: DATA_W too small");
   end
   if (PHYS_N > (1 << PHYS_W)) begin : g_bad_depth
      $error("banked_regfile: physical index too narrow");
   end

   phys_t pa, pb, pw, pl;

   bank_map u_map_a (.mode(cur_mode), .idx(rd_a_idx), .phys(pa));
   bank_map u_map_b (.mode(cur_mode), .idx(rd_b_idx), .phys(pb));
   bank_map u_map_w (.mode(cur_mode), .idx(wr_idx),   .phys(pw));
   bank_map u_map_l (.mode(lnk_mode), .idx(IDX_W'(LR_IDX)), .phys(pl));

   bank_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we_n (wr_en),
      .wa_n (pw),
      .wd_n (wr_data),
      .we_l (lnk_en),
      .wa_l (pl),
      .wd_l (lnk_data),
      .ra0  (pa),
      .rd0  (rd_a_data),
      .ra1  (pb),
      .rd1  (rd_b_data)
   );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        cur_mode,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              lnk_en,
   input logic [4:0]        lnk_mode,
   input logic [DATA_W-1:0] lnk_data
);
   // R1: first cycle out of reset sees cleared storage
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_a_data == '0 && rd_b_data == '0));

   // R6: a lone write is visible next cycle at the same index and mode
   a_r6_write_next: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lnk_en && rd_a_idx == wr_idx) |=>
      (!$stable(rd_a_idx) || !$stable(cur_mode) || rd_a_data == $past(wr_data)));

   // R7: link data lands in R14 of the target mode
   a_r7_link_lands: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_en |=> ((cur_mode != $past(lnk_mode)) || (rd_b_idx != 4'd14)
                  || rd_b_data == $past(lnk_data)));

   // R8: link write wins a collision with the normal write
   a_r8_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lnk_en && wr_idx == 4'd14 && cur_mode == lnk_mode) |=>
      (!$stable(cur_mode) || rd_a_idx != 4'd14 || rd_a_data == $past(lnk_data)));

   // R9: both ports agree when they address the same register
   a_r9_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
   .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
   .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .lnk_en(lnk_en), .lnk_mode(lnk_mode), .lnk_data(lnk_data)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cur_mode = 5'b10000;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, lnk_data = '0;
   logic        wr_en = 1'b0, lnk_en = 1'b0;
   logic [4:0]  lnk_mode = 5'b10000;

   int n_chk = 0, n_bad = 0;
   logic [31:0] mdl [31];

   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
      SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

   banked_regfile uut (.*);

   always #10 clk = ~clk;

   // Reference mapping from the requirements: banked slots follow R0..R15.
   function automatic int ref_phys(logic [4:0] m, logic [3:0] r);
      int b;
      b = (m == FIQ) ? 0 : (m == IRQ) ? 1 : (m == SVC) ? 2 :
          (m == ABT) ? 3 : (m == UND) ? 4 : -1;
      if (b >= 0 && (r == 13 || r == 14)) return 21 + 2 * b + (int'(r) - 13);
      if (b == 0 && r >= 8 && r <= 12) return 16 + int'(r) - 8;
      return int'(r);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drv(logic [4:0] m, logic [3:0] ra, logic [3:0] rb,
                      logic we, logic [3:0] wi, logic [31:0] wd,
                      logic le, logic [4:0] lm, logic [31:0] ld);
      cur_mode = m; rd_a_idx = ra; rd_b_idx = rb;
      wr_en = we; wr_idx = wi; wr_data = wd;
      lnk_en = le; lnk_mode = lm; lnk_data = ld;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      if (wr_en) mdl[ref_phys(cur_mode, wr_idx)] = wr_data;
      if (lnk_en) mdl[ref_phys(lnk_mode, 4'd14)] = lnk_data;
      @(negedge clk);
      wr_en = 1'b0; lnk_en = 1'b0;
   endtask

   task automatic rd(string tag, logic [4:0] m, logic [3:0] r, logic [31:0] exp);
      drv(m, r, r, 1'b0, '0, '0, 1'b0, USR, '0);
      chk(tag, rd_a_data, exp);
   endtask

   task automatic wr(logic [4:0] m, logic [3:0] r, logic [31:0] d);
      drv(m, r, r, 1'b1, r, d, 1'b0, USR, '0);
      tick();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [4:0] modes [9];
      modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b00000, 5'b10101};
      for (int i = 0; i < 31; i++) mdl[i] = '0;
      void'($urandom(32'd1234));
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      // R1: everything zero after reset
      for (int r = 0; r < 16; r++) begin
         rd("R1 user", USR, 4'(r), 32'h0);
         rd("R1 fiq", FIQ, 4'(r), 32'h0);
      end
      // R2: user writes visible in system mode
      wr(USR, 4'd5, 32'h0505_0505);
      wr(USR, 4'd13, 32'h1313_0000);
      rd("R2 sys r5", SYS, 4'd5, 32'h0505_0505);
      rd("R2 sys r13", SYS, 4'd13, 32'h1313_0000);
      // R3: unknown mode code behaves as user
      rd("R3 code00000 r13", 5'b00000, 4'd13, 32'h1313_0000);
      wr(5'b10100, 4'd9, 32'h0909_0909);
      rd("R3 user r9", USR, 4'd9, 32'h0909_0909);
      // R4: FIQ private r8-r12
      wr(FIQ, 4'd10, 32'hF10F_0010);
      rd("R4 user r10 untouched", USR, 4'd10, 32'h0);
      rd("R4 fiq r10", FIQ, 4'd10, 32'hF10F_0010);
      rd("R4 fiq r9 private", FIQ, 4'd9, 32'h0);
      rd("R4 irq r9 shared", IRQ, 4'd9, 32'h0909_0909);
      // R5: private r13 per exception mode, shared low registers
      wr(IRQ, 4'd13, 32'h1A1A_1A1A);
      rd("R5 svc r13", SVC, 4'd13, 32'h0);
      rd("R5 user r13", USR, 4'd13, 32'h1313_0000);
      rd("R5 irq r13", IRQ, 4'd13, 32'h1A1A_1A1A);
      rd("R5 abt r5 shared", ABT, 4'd5, 32'h0505_0505);
      // R6: same-cycle read returns old value, new value next cycle
      drv(USR, 4'd3, 4'd3, 1'b1, 4'd3, 32'hCAFE_0003, 1'b0, USR, '0);
      chk("R6 same cycle old", rd_a_data, 32'h0);
      tick();
      rd("R6 next cycle new", USR, 4'd3, 32'hCAFE_0003);
      // R7: link write into UND r14 only
      drv(USR, 4'd14, 4'd14, 1'b0, '0, '0, 1'b1, UND, 32'h0000_1234);
      tick();
      rd("R7 und r14", UND, 4'd14, 32'h0000_1234);
      rd("R7 user r14", USR, 4'd14, 32'h0);
      rd("R7 abt r14", ABT, 4'd14, 32'h0);
      // R8: collision, link wins
      drv(SVC, 4'd14, 4'd14, 1'b1, 4'd14, 32'hBAD0_BAD0, 1'b1, SVC, 32'h600D_600D);
      tick();
      rd("R8 svc r14", SVC, 4'd14, 32'h600D_600D);
      // R9: ports independent
      drv(USR, 4'd5, 4'd3, 1'b0, '0, '0, 1'b0, USR, '0);
      chk("R9 port a", rd_a_data, 32'h0505_0505);
      chk("R9 port b", rd_b_data, 32'hCAFE_0003);
      // Random mix against the reference model
      for (int k = 0; k < 3000; k++) begin
         drv(modes[$urandom % 9], 4'($urandom), 4'($urandom),
             1'($urandom), 4'($urandom), $urandom,
             ($urandom % 4) == 0, modes[$urandom % 9], $urandom);
         chk("R5 rand port a", rd_a_data, mdl[ref_phys(cur_mode, rd_a_idx)]);
         chk("R9 rand port b", rd_b_data, mdl[ref_phys(cur_mode, rd_b_idx)]);
         tick();
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule